// File: doc/BRIEF.md
# Embedded-Clock Frame Aligner with Lock Detection

This block sits behind a bit-level clock recovery stage. Each cycle of its bit clock it takes one recovered serial bit. The stream carries 28-bit frames. Each frame holds a 24-bit payload, an inversion flag for DC balance, a parity bit and two fixed boundary bits. The boundary bits put a 0-to-1 transition on the line at every frame seam. Framing is found on live, arbitrary payload; the sender never emits a training pattern.

In search mode the aligner treats one bit position as the candidate frame start. It accepts that position after four consecutive frames show correct boundary bits and good parity. Each failed candidate moves the search one bit position, so every position is eventually tried. Once locked, the aligner removes the overhead bits, re-inverts the payload when the flag is set, and presents a 24-bit word with a one-cycle word strobe. A parity failure alone keeps lock and raises an error pulse alongside the word. A missing boundary drops lock at once. Without any outside help the aligner then retests the same position and, failing that, searches again.

An output-enable input gates the word data and the word strobe. A polarity input picks whether the strobe pulses high or low.

Top module: `ecl_frame_aligner`

## Requirements
- R1: Frame layout, in the order the bits arrive:
  - bit 0 is a 1 (start boundary);
  - bits 1 to 24 carry the transmitted payload, least significant bit first;
  - bit 25 is the inversion flag, where 1 means the payload was sent inverted;
  - bit 26 is parity, chosen so that the XOR of bits 1 to 26 is 0;
  - bit 27 is a 0 (end boundary).
- R2: `lock` is low from reset. It rises only after four consecutive frames at one alignment pass both the boundary check and the parity check. On a stream aligned to the first bit after reset, `lock` rises with the fourth frame.
- R3: With no training pattern, the block locks on random payload that starts at any bit offset. Each failed candidate advances the tested position by one bit.
- R4: A word appears in the cycle after the frame's last bit is sampled. The strobe is active for that one cycle only. The word equals the payload, re-inverted when the flag is 1.
- R5: The word strobe and nonzero word data occur only while `lock` is high. `lock` rises in the cycle of the first word. It falls in the cycle where the failing frame's word would have appeared, and no strobe is given in that cycle.
- R6: A single frame with a wrong boundary bit drops lock at once. The same alignment is tested first: if the next four frames are good, `lock` rises again with the fourth of them.
- R7: After the stream shifts by one bit while locked, lock drops. The block then relocks at the new alignment by itself.
- R8: While locked, a frame with correct boundaries but bad parity still delivers its word and keeps lock. `word_err` is high for exactly that strobe cycle. `word_err` is never high without a strobe.
- R9: With `out_en` low, `word_data` and `word_clk` are 0. `lock` is not affected by `out_en`.
- R10: With `stb_pol` = 1, `word_clk` idles at 0 and pulses to 1. With `stb_pol` = 0, it idles at 1 and pulses to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_bit | input | 1 | Recovered serial bit, one per clock |
| out_en | input | 1 | Gates word data and word strobe |
| stb_pol | input | 1 | 1: strobe active high, 0: strobe active low |
| lock | output | 1 | Frame alignment locked; words valid |
| word_data | output | 24 | Decoded payload word |
| word_clk | output | 1 | Word strobe, one cycle per frame |
| word_err | output | 1 | Parity error pulse with the affected word |

## Verification
Suppose the phase counter or the lock state is wrong inside the block. At the ports, a strobe would then appear at a bit position other than a frame's last bit, or words would not match the payload that was sent. Both show within one frame, 28 cycles. The bench tracks which bit of which frame was last driven, so every strobe is tied to an exact frame. Lock acquisition and relock from a dropped frame are timed to the exact frame. Bit slips and arbitrary start offsets are checked by matching every word delivered after relock.

// File: rtl/ecl_pkg.sv
package ecl_pkg;

    localparam int unsigned PAY_W_DEF    = 24;
    localparam int unsigned OVH_W        = 4;
    localparam int unsigned LOCK_RUN_DEF = 4;

    typedef enum logic {
        ST_SEARCH = 1'b0,
        ST_LOCKED = 1'b1
    } align_st_t;

    typedef struct packed {
        logic frame_end;
        logic edge_ok;
        logic par_ok;
    } frame_evt_t;

    function automatic logic strobe_level(input logic active, input logic pol_hi);
        return ~(active ^ pol_hi);
    endfunction

endpackage

// File: rtl/ecl_bit_window.sv
module ecl_bit_window #(
    parameter int unsigned FRAME_W = 28
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ser_bit,
    input  logic               retry_shift,
    output logic               frame_end,
    output logic [FRAME_W-1:0] win
);
    localparam int unsigned PH_W = $clog2(FRAME_W);
    localparam int unsigned LAST = FRAME_W - 1;

    logic [FRAME_W-1:0] sreg_q;
    logic [PH_W-1:0]    phase_q;

    assign win       = {ser_bit, sreg_q[FRAME_W-1:1]};
    assign frame_end = (phase_q == PH_W'(LAST));

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg_q  <= '0;
            phase_q <= '0;
        end else begin
            sreg_q <= win;
            if (frame_end) begin
                phase_q <= retry_shift ? PH_W'(1) : '0;
            end else begin
                phase_q <= phase_q + PH_W'(1);
            end
        end
    end

    AST_PHASE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        phase_q <= PH_W'(LAST)); // R1

    AST_SLIP_SHORTENS: assert property (@(posedge clk) disable iff (rst)
        (frame_end && retry_shift) |=> (phase_q == PH_W'(1))); // R3

endmodule

// File: rtl/ecl_frame_check.sv
module ecl_frame_check
    import ecl_pkg::*;
#(
    parameter int unsigned PAY_W = 24
) (
    input  logic [PAY_W+OVH_W-1:0] win,
    input  logic                   frame_end,
    output frame_evt_t             evt,
    output logic [PAY_W-1:0]       pay
);
    localparam int unsigned POS_START = 0;
    localparam int unsigned POS_PAY   = 1;
    localparam int unsigned POS_INV   = PAY_W + 1;
    localparam int unsigned POS_PAR   = PAY_W + 2;
    localparam int unsigned POS_END   = PAY_W + 3;

    always_comb begin
        evt.frame_end = frame_end;
        evt.edge_ok   = win[POS_START] & ~win[POS_END];
        evt.par_ok    = ~(^win[POS_PAR:POS_PAY]);
    end

    for (genvar i = 0; i < PAY_W; i++) begin : g_uninv
        assign pay[i] = win[POS_PAY + i] ^ win[POS_INV];
    end

endmodule

// File: rtl/ecl_lock_fsm.sv
module ecl_lock_fsm
    import ecl_pkg::*;
#(
    parameter int unsigned LOCK_RUN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  frame_evt_t evt,
    output logic       retry_shift,
    output logic       take_word,
    output logic       lock
);
    localparam int unsigned RUN_W = $clog2(LOCK_RUN + 1);

    align_st_t        st_q, st_n;
    logic [RUN_W-1:0] run_q, run_n;
    logic             good;

    assign good = evt.edge_ok & evt.par_ok;
    assign lock = (st_q == ST_LOCKED);

    always_comb begin
        st_n        = st_q;
        run_n       = run_q;
        take_word   = 1'b0;
        retry_shift = 1'b0;
        if (evt.frame_end) begin
            case (st_q)
                ST_SEARCH: begin
                    if (good) begin
                        if (run_q == RUN_W'(LOCK_RUN - 1)) begin
                            st_n      = ST_LOCKED;
                            run_n     = '0;
                            take_word = 1'b1;
                        end else begin
                            run_n = run_q + RUN_W'(1);
                        end
                    end else begin
                        run_n       = '0;
                        retry_shift = 1'b1;
                    end
                end
                ST_LOCKED: begin
                    if (evt.edge_ok) begin
                        take_word = 1'b1;
                    end else begin
                        st_n  = ST_SEARCH;
                        run_n = '0;
                    end
                end
                default: st_n = ST_SEARCH;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_SEARCH;
            run_q <= '0;
        end else begin
            st_q  <= st_n;
            run_q <= run_n;
        end
    end

    AST_LOCK_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        $rose(lock) |-> ($past(run_q) == RUN_W'(LOCK_RUN - 1))); // R2

    AST_EDGE_MISS_DROPS: assert property (@(posedge clk) disable iff (rst)
        (lock && evt.frame_end && !evt.edge_ok) |=> !lock); // R6

    AST_PARITY_KEEPS_LOCK: assert property (@(posedge clk) disable iff (rst)
        (lock && evt.frame_end && evt.edge_ok && !evt.par_ok) |=> lock); // R8

    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (rst)
        run_q < RUN_W'(LOCK_RUN)); // R2

endmodule

// File: rtl/ecl_word_out.sv
module ecl_word_out
    import ecl_pkg::*;
#(
    parameter int unsigned PAY_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take_word,
    input  logic             par_err,
    input  logic [PAY_W-1:0] pay,
    input  logic             lock,
    input  logic             out_en,
    input  logic             stb_pol,
    output logic [PAY_W-1:0] word_data,
    output logic             word_clk,
    output logic             word_err
);
    logic [PAY_W-1:0] data_q;
    logic             stb_q;
    logic             err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            stb_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            stb_q <= take_word;
            err_q <= take_word & par_err;
            if (take_word) begin
                data_q <= pay;
            end
        end
    end

    assign word_data = (out_en && lock) ? data_q : '0;
    assign word_clk  = out_en ? strobe_level(stb_q, stb_pol) : 1'b0;
    assign word_err  = err_q;

    AST_STB_WITH_LOCK: assert property (@(posedge clk) disable iff (rst)
        stb_q |-> lock); // R5

    AST_ERR_WITH_STB: assert property (@(posedge clk) disable iff (rst)
        err_q |-> stb_q); // R8

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
        stb_q |=> !stb_q); // R4

endmodule

// File: rtl/ecl_frame_aligner.sv
module ecl_frame_aligner
    import ecl_pkg::*;
#(
    parameter int unsigned PAY_W    = PAY_W_DEF,
    parameter int unsigned LOCK_RUN = LOCK_RUN_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_bit,
    input  logic             out_en,
    input  logic             stb_pol,
    output logic             lock,
    output logic [PAY_W-1:0] word_data,
    output logic             word_clk,
    output logic             word_err
);
    localparam int unsigned FRAME_W = PAY_W + OVH_W;

    logic               frame_end;
    logic [FRAME_W-1:0] win;
    logic               retry_shift;
    logic               take_word;
    frame_evt_t         evt;
    logic [PAY_W-1:0]   pay;

    ecl_bit_window #(.FRAME_W(FRAME_W)) u_window (
        .clk         (clk),
        .rst         (rst),
        .ser_bit     (ser_bit),
        .retry_shift (retry_shift),
        .frame_end   (frame_end),
        .win         (win)
    );

    ecl_frame_check #(.PAY_W(PAY_W)) u_check (
        .win       (win),
        .frame_end (frame_end),
        .evt       (evt),
        .pay       (pay)
    );

    ecl_lock_fsm #(.LOCK_RUN(LOCK_RUN)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .retry_shift (retry_shift),
        .take_word   (take_word),
        .lock        (lock)
    );

    ecl_word_out #(.PAY_W(PAY_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .take_word (take_word),
        .par_err   (~evt.par_ok),
        .pay       (pay),
        .lock      (lock),
        .out_en    (out_en),
        .stb_pol   (stb_pol),
        .word_data (word_data),
        .word_clk  (word_clk),
        .word_err  (word_err)
    );

endmodule

// File: tb/ecl_frame_aligner_tb.sv
module ecl_frame_aligner_tb;
    localparam int CLK_P = 10;
    localparam int PW    = 24;
    localparam int FW    = 28;
    localparam int NMAX  = 2048;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_bit = 1'b0;
    logic out_en = 1'b1;
    logic stb_pol = 1'b1;
    logic lock;
    logic [PW-1:0] word_data;
    logic word_clk;
    logic word_err;

    ecl_frame_aligner u_dut (
        .clk(clk), .rst(rst), .ser_bit(ser_bit), .out_en(out_en), .stb_pol(stb_pol),
        .lock(lock), .word_data(word_data), .word_clk(word_clk), .word_err(word_err)
    );

    always #(CLK_P/2) clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int drv_idx = -1;
    int drv_pos = -1;
    int fidx = 0;
    int rise_idx = -1;
    int fall_idx = -1;
    int words = 0;
    int err_pulses = 0;
    logic lock_prev = 1'b0;
    logic mon_stb;
    bit mon_en = 1'b0;
    logic [PW-1:0] exp_pay [0:NMAX-1];
    logic exp_perr [0:NMAX-1];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [FW-1:0] encode(input logic [PW-1:0] d, input logic inv,
                                             input logic bad_par, input logic bad_start);
        logic [FW-1:0] f;
        logic [PW-1:0] w;
        w = inv ? ~d : d;
        f[0] = ~bad_start;
        f[24:1] = w;
        f[25] = inv;
        f[26] = (^{w, inv}) ^ bad_par;
        f[27] = 1'b0;
        return f;
    endfunction

    task automatic send_bit(input logic b, input int idx, input int pos);
        ser_bit = b;
        drv_idx = idx;
        drv_pos = pos;
        @(negedge clk);
    endtask

    task automatic send_frame(input logic bad_par, input logic bad_start);
        logic [PW-1:0] d;
        logic inv;
        logic [FW-1:0] f;
        d = PW'($urandom);
        inv = 1'($urandom);
        f = encode(d, inv, bad_par, bad_start);
        exp_pay[fidx] = d;
        exp_perr[fidx] = bad_par;
        for (int i = 0; i < FW; i++) send_bit(f[i], fidx, i);
        fidx++;
    endtask

    task automatic send_good(input int n);
        for (int i = 0; i < n; i++) send_frame(1'b0, 1'b0);
    endtask

    task automatic do_reset();
        mon_en = 1'b0;
        rst = 1'b1;
        ser_bit = 1'b0;
        drv_pos = -1;
        repeat (3) @(negedge clk);
        chk(lock == 1'b0, "R2 lock low in reset", 32'(lock), 0);
        chk(word_data == '0, "R5 data zero in reset", 32'(word_data), 0);
        chk(word_clk == ~stb_pol, "R10 strobe idle in reset", 32'(word_clk), 32'(~stb_pol));
        chk(word_err == 1'b0, "R8 err low in reset", 32'(word_err), 0);
        rst = 1'b0;
        rise_idx = -1;
        fall_idx = -1;
        mon_en = 1'b1;
    endtask

    // port monitor, sampling one time unit after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst || !mon_en) begin
                lock_prev = 1'b0;
            end else begin
                mon_stb = out_en && (word_clk == stb_pol);
                if (out_en) begin
                    if (mon_stb) begin
                        words++;
                        if (word_err) err_pulses++;
                        chk(drv_pos == FW-1, "R4 strobe only after last bit", 32'(drv_pos), FW-1);
                        chk(lock, "R5 strobe needs lock", 32'(lock), 1);
                        if (drv_pos == FW-1) begin
                            chk(word_data == exp_pay[drv_idx], "R4 decoded word",
                                32'(word_data), 32'(exp_pay[drv_idx]));
                            chk(word_err == exp_perr[drv_idx], "R8 parity flag",
                                32'(word_err), 32'(exp_perr[drv_idx]));
                        end
                    end else begin
                        chk(word_err == 1'b0, "R8 err only with strobe", 32'(word_err), 0);
                    end
                    if (lock && !lock_prev) begin
                        chk(mon_stb, "R5 lock rises with first word", 32'(mon_stb), 1);
                        rise_idx = drv_idx;
                    end
                    if (!lock && lock_prev) begin
                        chk(!mon_stb, "R5 no word on lock drop", 32'(mon_stb), 0);
                        fall_idx = drv_idx;
                    end
                    if (!lock) chk(word_data == '0, "R5 data zero while unlocked", 32'(word_data), 0);
                end else begin
                    chk(word_data == '0 && word_clk == 1'b0, "R9 outputs gated",
                        {7'd0, word_clk, word_data}, 0);
                    if (lock && !lock_prev) rise_idx = drv_idx;
                    if (!lock && lock_prev) fall_idx = drv_idx;
                end
                lock_prev = lock;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int k;
        int w0;
        int e0;
        int f0;
        int pre;
        void'($urandom(32'd90817));
        @(negedge clk);

        // R2: aligned from reset, lock with the fourth frame
        do_reset();
        k = fidx;
        send_good(10);
        chk(rise_idx == k + 3, "R2 lock after four frames", 32'(rise_idx), 32'(k + 3));
        chk(lock, "R2 lock held", 32'(lock), 1);

        // R6: one missed boundary, retest same alignment
        k = fidx;
        send_frame(1'b0, 1'b1);
        send_good(6);
        chk(fall_idx == k, "R6 drop at bad frame", 32'(fall_idx), 32'(k));
        chk(rise_idx == k + 4, "R6 relock after four frames", 32'(rise_idx), 32'(k + 4));

        // R8: parity error while locked
        e0 = err_pulses;
        f0 = fall_idx;
        send_good(2);
        send_frame(1'b1, 1'b0);
        send_good(2);
        chk(err_pulses == e0 + 1, "R8 one error pulse", 32'(err_pulses), 32'(e0 + 1));
        chk(lock && fall_idx == f0, "R8 lock kept on parity error", 32'(fall_idx), 32'(f0));

        // R9: output enable gating
        out_en = 1'b0;
        send_good(5);
        chk(lock, "R9 lock unaffected by out_en", 32'(lock), 1);
        out_en = 1'b1;
        w0 = words;
        send_good(3);
        chk(words == w0 + 3, "R9 words resume", 32'(words), 32'(w0 + 3));

        // R10: active-low strobe
        stb_pol = 1'b0;
        w0 = words;
        send_good(8);
        chk(words == w0 + 8, "R10 active-low strobes", 32'(words), 32'(w0 + 8));
        stb_pol = 1'b1;
        w0 = words;
        send_good(4);
        chk(words == w0 + 4, "R10 active-high strobes", 32'(words), 32'(w0 + 4));

        // R7: one-bit slip while locked
        send_bit(1'b0, -1, -1);
        f0 = fidx;
        send_good(250);
        chk(fall_idx == f0, "R7 drop on slip", 32'(fall_idx), 32'(f0));
        chk(rise_idx > f0, "R7 relocked after slip", 32'(rise_idx), 32'(f0 + 1));
        chk(lock, "R7 lock at end", 32'(lock), 1);

        // R3: random offset start, no training pattern
        do_reset();
        pre = 1 + int'($urandom % (FW - 1));
        for (int i = 0; i < pre; i++) send_bit(1'($urandom), -1, -1);
        f0 = fidx;
        send_good(250);
        chk(lock, "R3 lock on random data", 32'(lock), 1);
        chk(rise_idx >= f0 + 3, "R3 four frames before lock", 32'(rise_idx), 32'(f0 + 3));

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule